// File: doc/BRIEF.md
# Double-Frequency Data/Clock Separator

This block sits after the edge detector of a double-frequency (FM) read channel. It receives a train of narrow pulses and sorts each one into a clock pulse or a data-one pulse. With an all-zeros pattern the pulses arrive once per bit cell. With an all-ones pattern they arrive twice per bit cell. Timing comes from counters running on an oversampling clock, and no one-shots are used.

A clock pulse opens a timing window. A pulse that lands inside that window is a one bit. The first pulse after the window has expired is the next clock pulse. Both outputs are re-formed to a fixed width. They reach the host only while an active-low read enable is asserted. The output gate switches only between pulses, so the host never sees a partial pulse.

The block tracks lock to the pulse stream. If two bit cells go by without a clock pulse, it reports loss of sync and treats the next pulse as a clock pulse.

Top module: `fm_clk_data_sep`

## Requirements
- R1: After reset both pulse outputs are low, `sync_lost_o` is 1 and the output gate is closed.
- R2: An input pulse counts at its rising edge, passed through a two-flop synchronizer and an edge detector. The resulting output pulse goes high right after the third rising clock edge, counted from the edge that first samples the input high. The first pulse after reset or after loss of sync is a clock pulse.
- R3: A clock pulse opens a window of `WIN_CYCLES` sample cycles, 12 by default (3/4 of a 16-cycle cell). A pulse whose edge is detected 1 to `WIN_CYCLES` cycles after the clock pulse is a data-one pulse and appears on `rd_data_o`.
- R4: A pulse detected more than `WIN_CYCLES` cycles after the last clock pulse, or detected while no window is open, is a clock pulse and appears on `rd_clk_o`.
- R5: A data-one pulse closes the window at once. A further pulse in the same cell is therefore a clock pulse, so at most one data pulse can occur per cell.
- R6: Each output pulse is high for exactly `PW_CYCLES` cycles (4 by default), however long the input pulse lasts.
- R7: The outputs are visible only while `rd_en_n` is 0. When neither pulse former is active, a change of `rd_en_n` takes effect one cycle later. While a pulse is active the change is held back until that pulse ends, so each pulse is either fully shown or fully hidden.
- R8: Suppose `2*CELL_CYCLES` cycles pass after a clock pulse with no further clock pulse. Then `sync_lost_o` rises on the cycle after the last of those cycles, which is the 33rd cycle by default. The next pulse clears it and counts as a clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_pulse_i | input | 1 | Narrow read pulses from the edge detector (asynchronous) |
| rd_en_n | input | 1 | Active-low read enable that gates the outputs |
| rd_clk_o | output | 1 | Formed read-clock pulse |
| rd_data_o | output | 1 | Formed read-data (one bit) pulse |
| sync_lost_o | output | 1 | High while the block is hunting for a clock pulse |

## Verification
A wrong window count moves a pulse from one output to the other on the first pulse near the window boundary. The boundary cases are detected exactly `WIN_CYCLES` and `WIN_CYCLES+1` cycles after a clock pulse. A window that stays open after a data pulse turns the next closely spaced pulse into a second data pulse within the same cell. A pulse former or gate that changes state at the wrong time shows within one pulse width as a short or clipped output pulse. A loss counter that is off by one shows as `sync_lost_o` rising one cycle early or late.

// File: rtl/fm_clk_data_sep.sv
module fm_clk_data_sep #(
  parameter int CELL_CYCLES = 16,
  parameter int WIN_CYCLES  = CELL_CYCLES * 3 / 4,
  parameter int PW_CYCLES   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_pulse_i,
  input  logic rd_en_n,
  output logic rd_clk_o,
  output logic rd_data_o,
  output logic sync_lost_o
);
  localparam int LOSS_CYCLES = 2 * CELL_CYCLES;
  localparam int WW = $clog2(WIN_CYCLES + 1);
  localparam int PWW = $clog2(PW_CYCLES + 1);
  localparam int IW = $clog2(LOSS_CYCLES + 1);

  initial begin
    assert (WIN_CYCLES > 0 && WIN_CYCLES < CELL_CYCLES)
      else $error("window must be shorter than a cell");
    assert (PW_CYCLES > 0 && 2 * PW_CYCLES <= CELL_CYCLES)
      else $error("pulse width must fit half a cell");
  end

  logic [2:0]     smp;
  logic [WW-1:0]  win_cnt;
  logic [PWW-1:0] clk_cnt, dat_cnt;
  logic [IW-1:0]  idle_cnt;
  logic           gate_on;

  wire edge_det = smp[1] & ~smp[2];
  wire win_open = (win_cnt != '0);
  wire is_clk   = edge_det & ~win_open;
  wire is_data  = edge_det & win_open;
  wire clk_act  = (clk_cnt != '0);
  wire dat_act  = (dat_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) smp <= '0;
    else        smp <= {smp[1:0], rd_pulse_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        win_cnt <= '0;
    else if (is_clk)   win_cnt <= WW'(WIN_CYCLES);
    else if (is_data)  win_cnt <= '0;
    else if (win_open) win_cnt <= win_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_cnt <= '0;
      dat_cnt <= '0;
    end else begin
      if (is_clk)       clk_cnt <= PWW'(PW_CYCLES);
      else if (clk_act) clk_cnt <= clk_cnt - 1'b1;
      if (is_data)      dat_cnt <= PWW'(PW_CYCLES);
      else if (dat_act) dat_cnt <= dat_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt    <= '0;
      sync_lost_o <= 1'b1;
    end else if (is_clk) begin
      idle_cnt    <= '0;
      sync_lost_o <= 1'b0;
    end else if (!sync_lost_o) begin
      if (idle_cnt == IW'(LOSS_CYCLES - 1)) sync_lost_o <= 1'b1;
      else                                  idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  gate_on <= 1'b0;
    else if (!clk_act && !dat_act) gate_on <= ~rd_en_n;
  end

  assign rd_clk_o  = clk_act & gate_on;
  assign rd_data_o = dat_act & gate_on;

  p_gate_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_on) |-> $past(clk_cnt == '0 && dat_cnt == '0));

  p_clk_no_clip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_clk_o) |-> $past(clk_cnt == PWW'(1)));

  p_data_no_clip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data_o) |-> $past(dat_cnt == PWW'(1)));

  p_lost_no_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost_o |-> win_cnt == '0);

  p_data_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_act) |-> win_cnt == '0);
endmodule

// File: tb/sim_fm_clk_data_sep.sv
module sim_fm_clk_data_sep;
  localparam int CELL = 16;
  localparam int WIN  = 12;
  localparam int PW   = 4;
  localparam int NV   = 10;
  // gap between input rising edges, expected class (1 = data one)
  localparam int GAP [NV] = '{0, 16, 8, 8, 12, 4, 13, 13, 8, 8};
  localparam bit EXPD[NV] = '{0, 0, 1, 0, 1, 0, 0, 0, 1, 0};
  // entries: 0 R2 first pulse clock; 2,4,8 R3 data (4 = window edge);
  // 1,3,6,7,9 R4 clock (6 = one past window); 5 R5 closed after data

  logic clk = 0, rst_n = 0, rd_pulse_i = 0, rd_en_n = 0;
  logic rd_clk_o, rd_data_o, sync_lost_o;
  int checks = 0, fails = 0;
  bit done = 0;

  fm_clk_data_sep #(.CELL_CYCLES(CELL), .WIN_CYCLES(WIN), .PW_CYCLES(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_pulse_i(rd_pulse_i), .rd_en_n(rd_en_n),
    .rd_clk_o(rd_clk_o), .rd_data_o(rd_data_o), .sync_lost_o(sync_lost_o));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // drives a two-cycle input pulse; returns just after the output should rise
  task automatic send();
    rd_pulse_i = 1;
    @(negedge clk);
    @(negedge clk);
    rd_pulse_i = 0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    int hi;
    idle(3);
    chk("R1 rd_clk_o", rd_clk_o, 0);
    chk("R1 rd_data_o", rd_data_o, 0);
    chk("R1 sync_lost_o", sync_lost_o, 1);
    rst_n = 1;
    idle(3);

    for (int i = 0; i < NV; i++) begin
      if (i > 0) idle(GAP[i] - 3);
      send();
      chk($sformatf("R3/R4/R5 vec%0d rd_data_o", i), rd_data_o, EXPD[i]);
      chk($sformatf("R3/R4/R5 vec%0d rd_clk_o", i), rd_clk_o, !EXPD[i]);
      chk($sformatf("R8 vec%0d sync_lost_o", i), sync_lost_o, 0);
    end

    idle(2 * CELL - 1);
    chk("R8 lock kept", sync_lost_o, 0);
    idle(1);
    chk("R8 lost", sync_lost_o, 1);
    idle(5);
    send();
    chk("R2 after loss is clock", rd_clk_o, 1);
    chk("R8 cleared", sync_lost_o, 0);
    for (int k = 0; k < PW - 1; k++) begin
      idle(1);
      chk("R6 width high", rd_clk_o, 1);
    end
    idle(1);
    chk("R6 width end", rd_clk_o, 0);

    idle(20);
    rd_pulse_i = 1;
    hi = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 12) rd_pulse_i = 0;
      if (rd_clk_o) hi++;
      if (rd_data_o) hi += 100;
    end
    checks++;
    if (hi != PW) begin
      fails++;
      $display("FAIL R6 long input act=%0d exp=%0d", hi, PW);
    end

    idle(20);
    send();
    chk("R7 open pulse", rd_clk_o, 1);
    rd_en_n = 1;
    for (int k = 0; k < PW - 1; k++) begin
      idle(1);
      chk("R7 no clip on close", rd_clk_o, 1);
    end
    idle(1);
    chk("R7 pulse ended", rd_clk_o, 0);
    idle(20);
    send();
    chk("R7 hidden", rd_clk_o, 0);
    rd_en_n = 0;
    for (int k = 0; k < PW; k++) begin
      idle(1);
      chk("R7 open deferred", rd_clk_o, 0);
    end
    idle(20);
    send();
    chk("R7 reopened", rd_clk_o, 1);

    idle(5);
    finish_run();
  end
endmodule